// File: doc/BRIEF.md
# Raster Sync and Blank Generator

This block turns the horizontal and vertical beam positions of a raster counter into the timing strobes a display needs: horizontal sync, vertical sync, a composite sync and a blanking level. It also reports the last position of each line and the last line of a frame, so the counter that feeds it knows when to wrap. The counter itself lives outside. The block receives the current horizontal and vertical counts on every clock, together with a flag that marks the long field of an interlaced pair.

A 16-bit control word chooses, per timing group, between fixed built-in values and values held in programmable registers. The control word also sets the polarity of each sync output and picks between the 625-line and 525-line fixed frame lengths. The control word and the programmable values are written through a simple write port. Writes collect in a staging copy, and that copy becomes the working set only when a line ends. A line that is already being drawn therefore always finishes with the values it started with.

Each sync or blank output is a span. It starts one cycle after the count reaches its start value, ends one cycle after the count reaches its stop value, and stays on between the two, including across the counter wrap. When the interlace long-field flag is high, the vertical sync span changes state at a mid-line horizontal position instead of at the start of the line.

Top module: `raster_sync_gen`

## Requirements
- R1: After reset every span is inactive and the control word is zero. With a zero control word the fixed timing and the 525-line frame length apply, and all sync outputs are active-low, so hsync_o, vsync_o and csync_o read 1 and blank_o reads 0.
- R2: line_end_o is high while h_cnt equals the effective line total. frame_end_o is high only while line_end_o is high and v_cnt equals the effective frame total. The fixed line total is 227. The fixed frame total is 261 when control bit 6 is 0 and 311 when control bit 6 is 1.
- R3: The write port has the following address map. Address 0 is the control word, 1 is the line total, 2 and 3 are the hsync start and stop, 4 and 5 are the hblank start and stop, and 6 is the frame total. Addresses 7 and 8 are the vsync start and stop, 9 and 10 are the vblank start and stop, and 11 is the mid-line position. Writes to addresses 12 to 15 change nothing.
- R4: A write is held in a staging copy. It becomes effective only at the clock edge that ends a cycle in which line_end_o is high, so it first applies at the first position of the next line.
- R5: Horizontal sync and horizontal blank turn on in the cycle after h_cnt equals their start value and turn off in the cycle after h_cnt equals their stop value. They hold their state in between, across the wrap as well. The fixed values are 15 to 25 for sync and 1 to 33 for blank. When control bit 9 is set, both come from registers 2 to 5.
- R6: The vertical spans compare v_cnt against their start and stop only on particular cycles. Vertical blank compares when h_cnt is 0. Vertical sync compares when h_cnt is 0, or when h_cnt equals the register 11 value if long_field is high. The fixed values are 2 to 4 for vertical sync and 0 to 28 for vertical blank. Control bit 10 selects registers 7 and 8 for vertical sync, and bit 13 selects registers 9 and 10 for vertical blank.
- R7: The active level of composite sync is the active level of horizontal sync outside the vertical sync span and its inverse inside that span.
- R8: blank_o is high when control bit 4 is set and either horizontal or vertical blank is active. When bit 4 is clear, blank_o stays low.
- R9: Control bits 1, 2 and 3 make hsync_o, vsync_o and csync_o active-high when set. When clear, those outputs are active-low.
- R10: Control bit 8 takes the line total and the frame total from registers 1 and 6 instead of the fixed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_cnt | input | HW (8) | Horizontal beam position |
| v_cnt | input | VW (9) | Vertical beam position |
| long_field | input | 1 | High during the long field of an interlaced pair |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | DW (16) | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity from control bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity from control bit 2 |
| csync_o | output | 1 | Composite sync, polarity from control bit 3 |
| blank_o | output | 1 | Blanking, active high |
| line_end_o | output | 1 | Current position is the last of the line |
| frame_end_o | output | 1 | Current position is the last of the frame |

## Verification
A span flop left in the wrong state shows on its sync or blank pin within one cycle. It then stays wrong until the counter next reaches a start or stop value, so the fault persists for the rest of the span rather than fading. If the staging copy is committed at the wrong moment, the new totals or polarities appear mid-line. That is visible at once as a line_end_o pulse or a polarity change at a position the model does not expect. The bench drives the counts itself and predicts every output one edge ahead. Any such divergence is therefore caught on the first cycle it reaches a port.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

   localparam int NREG = 12;

   // register addresses
   localparam int A_CTRL      = 0;
   localparam int A_LINE_LEN  = 1;
   localparam int A_HS_ON     = 2;
   localparam int A_HS_OFF    = 3;
   localparam int A_HB_ON     = 4;
   localparam int A_HB_OFF    = 5;
   localparam int A_FRAME_LEN = 6;
   localparam int A_VS_ON     = 7;
   localparam int A_VS_OFF    = 8;
   localparam int A_VB_ON     = 9;
   localparam int A_VB_OFF    = 10;
   localparam int A_MID       = 11;

   // control word bit positions
   localparam int B_HS_POS   = 1;
   localparam int B_VS_POS   = 2;
   localparam int B_CS_POS   = 3;
   localparam int B_BLANK_EN = 4;
   localparam int B_PAL      = 6;
   localparam int B_VAR_TOT  = 8;
   localparam int B_VAR_H    = 9;
   localparam int B_VAR_VS   = 10;
   localparam int B_VAR_VB   = 13;

   // built-in timing
   localparam logic [15:0] FIX_LINE       = 16'h00E3;
   localparam logic [15:0] FIX_FRAME_625  = 16'h0137;
   localparam logic [15:0] FIX_FRAME_525  = 16'h0105;
   localparam logic [15:0] FIX_HS_ON      = 16'h000F;
   localparam logic [15:0] FIX_HS_OFF     = 16'h0019;
   localparam logic [15:0] FIX_HB_ON      = 16'h0001;
   localparam logic [15:0] FIX_HB_OFF     = 16'h0021;
   localparam logic [15:0] FIX_VS_ON      = 16'h0002;
   localparam logic [15:0] FIX_VS_OFF     = 16'h0004;
   localparam logic [15:0] FIX_VB_ON      = 16'h0000;
   localparam logic [15:0] FIX_VB_OFF     = 16'h001C;
   localparam logic [15:0] FIX_MID        = 16'h0071;

   function automatic logic [15:0] reset_value(input int idx);
      case (idx)
         A_LINE_LEN:  return FIX_LINE;
         A_HS_ON:     return FIX_HS_ON;
         A_HS_OFF:    return FIX_HS_OFF;
         A_HB_ON:     return FIX_HB_ON;
         A_HB_OFF:    return FIX_HB_OFF;
         A_FRAME_LEN: return FIX_FRAME_625;
         A_VS_ON:     return FIX_VS_ON;
         A_VS_OFF:    return FIX_VS_OFF;
         A_VB_ON:     return FIX_VB_ON;
         A_VB_OFF:    return FIX_VB_OFF;
         A_MID:       return FIX_MID;
         default:     return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/rsg_regfile.sv
module rsg_regfile #(
   parameter int NREG = 12,
   parameter int DW   = 16,
   parameter int AW   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic                     commit,
   output logic [NREG-1:0][DW-1:0]  live
);
   logic [NREG-1:0][DW-1:0] staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            staged[i] <= DW'(rsg_pkg::reset_value(i));
            live[i]   <= DW'(rsg_pkg::reset_value(i));
         end
      end else begin
         if (commit)
            live <= staged;
         if (wr_en && (32'(wr_addr) < NREG))
            staged[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/rsg_span.sv
module rsg_span #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] on_at,
   input  logic [W-1:0] off_at,
   output logic         active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active <= 1'b0;
      else if (step) begin
         if (cnt == on_at)
            active <= 1'b1;
         else if (cnt == off_at)
            active <= 1'b0;
      end
   end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
   parameter int HW = 8,
   parameter int VW = 9,
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] h_cnt,
   input  logic [VW-1:0] v_cnt,
   input  logic          long_field,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          csync_o,
   output logic          blank_o,
   output logic          line_end_o,
   output logic          frame_end_o
);
   import rsg_pkg::*;

   localparam int NSPAN = 2;

   if (HW < 8 || HW > DW || VW < 9 || VW > DW || (2**AW) < NREG) begin : g_param_check
      $error("raster_sync_gen: parameter set out of range");
   end

   logic [NREG-1:0][DW-1:0] regs;
   logic [DW-1:0]           ctl;
   logic [HW-1:0]           line_len;
   logic [VW-1:0]           frame_len;
   logic [HW-1:0]           v_edge;
   logic [NSPAN-1:0][HW-1:0] h_on, h_off;
   logic [NSPAN-1:0][VW-1:0] v_on, v_off;
   logic [NSPAN-1:0]        h_act, v_act, v_step;
   logic                    cs_act;
   logic                    unused_bits;

   rsg_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .commit  (line_end_o),
      .live    (regs)
   );

   assign ctl         = regs[A_CTRL];
   assign unused_bits = ^regs;

   // totals and line/frame ends
   assign line_len  = ctl[B_VAR_TOT] ? regs[A_LINE_LEN][HW-1:0] : HW'(FIX_LINE);
   assign frame_len = ctl[B_VAR_TOT] ? regs[A_FRAME_LEN][VW-1:0] :
                      (ctl[B_PAL] ? VW'(FIX_FRAME_625) : VW'(FIX_FRAME_525));
   assign line_end_o  = (h_cnt == line_len);
   assign frame_end_o = line_end_o && (v_cnt == frame_len);

   // horizontal group: index 0 sync, index 1 blank
   assign h_on[0]  = ctl[B_VAR_H] ? regs[A_HS_ON][HW-1:0]  : HW'(FIX_HS_ON);
   assign h_off[0] = ctl[B_VAR_H] ? regs[A_HS_OFF][HW-1:0] : HW'(FIX_HS_OFF);
   assign h_on[1]  = ctl[B_VAR_H] ? regs[A_HB_ON][HW-1:0]  : HW'(FIX_HB_ON);
   assign h_off[1] = ctl[B_VAR_H] ? regs[A_HB_OFF][HW-1:0] : HW'(FIX_HB_OFF);

   // vertical group: index 0 sync, index 1 blank
   assign v_on[0]  = ctl[B_VAR_VS] ? regs[A_VS_ON][VW-1:0]  : VW'(FIX_VS_ON);
   assign v_off[0] = ctl[B_VAR_VS] ? regs[A_VS_OFF][VW-1:0] : VW'(FIX_VS_OFF);
   assign v_on[1]  = ctl[B_VAR_VB] ? regs[A_VB_ON][VW-1:0]  : VW'(FIX_VB_ON);
   assign v_off[1] = ctl[B_VAR_VB] ? regs[A_VB_OFF][VW-1:0] : VW'(FIX_VB_OFF);

   // vertical sync moves to mid-line during the long field
   assign v_edge    = long_field ? regs[A_MID][HW-1:0] : '0;
   assign v_step[0] = (h_cnt == v_edge);
   assign v_step[1] = (h_cnt == '0);

   for (genvar gi = 0; gi < NSPAN; gi++) begin : g_span
      rsg_span #(.W(HW)) u_h (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (1'b1),
         .cnt    (h_cnt),
         .on_at  (h_on[gi]),
         .off_at (h_off[gi]),
         .active (h_act[gi])
      );
      rsg_span #(.W(VW)) u_v (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (v_step[gi]),
         .cnt    (v_cnt),
         .on_at  (v_on[gi]),
         .off_at (v_off[gi]),
         .active (v_act[gi])
      );
   end

   // composite: serrated (inverted) during vertical sync
   assign cs_act  = h_act[0] ^ v_act[0];

   assign hsync_o = ~(h_act[0] ^ ctl[B_HS_POS]);
   assign vsync_o = ~(v_act[0] ^ ctl[B_VS_POS]);
   assign csync_o = ~(cs_act   ^ ctl[B_CS_POS]);
   assign blank_o = ctl[B_BLANK_EN] & (h_act[1] | v_act[1]);

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
   parameter int HW = 8,
   parameter int DW = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HW-1:0]      h_cnt,
   input logic               line_end_o,
   input logic               frame_end_o,
   input logic               blank_o,
   input logic [DW-1:0]      ctl,
   input logic [1:0][HW-1:0] h_on,
   input logic [1:0][HW-1:0] h_off,
   input logic [1:0]         h_act
);
   AST_HS_SET_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt == h_on[0]) |=> h_act[0]); // R5
   AST_HS_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt == h_off[0] && h_cnt != h_on[0]) |=> !h_act[0]); // R5
   AST_HS_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt != h_off[0] && h_cnt != h_on[0]) |=> $stable(h_act[0])); // R5
   AST_FRAME_END_IN_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> line_end_o); // R2
   AST_CTL_ONLY_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end_o |=> $stable(ctl)); // R4
   AST_BLANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[4] |-> !blank_o); // R8
endmodule

bind raster_sync_gen rsg_checker #(.HW(HW), .DW(DW)) u_rsg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .h_cnt       (h_cnt),
   .line_end_o  (line_end_o),
   .frame_end_o (frame_end_o),
   .blank_o     (blank_o),
   .ctl         (ctl),
   .h_on        (h_on),
   .h_off       (h_off),
   .h_act       (h_act)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb_top;
   localparam int HW = 8;
   localparam int VW = 9;
   localparam int AW = 4;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic          long_field;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          hsync_o, vsync_o, csync_o, blank_o, line_end_o, frame_end_o;

   always #10 clk = ~clk;

   raster_sync_gen #(.HW(HW), .VW(VW), .AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .long_field(long_field), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .csync_o(csync_o), .blank_o(blank_o), .line_end_o(line_end_o),
      .frame_end_o(frame_end_o)
   );

   typedef struct packed {
      logic hs;
      logic vs;
      logic cs;
      logic bl;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;

   // reference model state
   logic [15:0] m_staged [12];
   logic [15:0] m_live   [12];
   logic        m_hs, m_hb, m_vs, m_vb;

   function automatic int dflt(input int i);
      case (i)
         1: return 227;  2: return 15;  3: return 25;  4: return 1;
         5: return 33;   6: return 311; 7: return 2;   8: return 4;
         9: return 0;    10: return 28; 11: return 113;
         default: return 0;
      endcase
   endfunction

   function automatic int pick(input int idx, input bit sel, input int mask);
      return (sel ? int'(m_live[idx]) : dflt(idx)) & mask;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // driver: one counter position per call, expected outputs pushed to the scoreboard
   task automatic step(input int h, input int v, input bit lf = 1'b0,
                       input bit we = 1'b0, input int a = 0, input logic [15:0] d = 16'h0);
      logic [15:0] c;
      int          ltot, ftot, vedge;
      bit          el, ef;
      exp_t        e;
      @(negedge clk);
      h_cnt = HW'(h); v_cnt = VW'(v); long_field = lf;
      wr_en = we; wr_addr = AW'(a); wr_data = d;
      #5;
      c    = m_live[0];
      ltot = c[8] ? (int'(m_live[1]) & 255) : 227;                  // R10
      ftot = c[8] ? (int'(m_live[6]) & 511) : (c[6] ? 311 : 261);
      el   = (h == ltot);
      ef   = el && (v == ftot);
      chk("R2 line_end", line_end_o, el);
      chk("R2 frame_end", frame_end_o, ef);
      // horizontal spans (R5)
      if (h == pick(2, c[9], 255)) m_hs = 1'b1;
      else if (h == pick(3, c[9], 255)) m_hs = 1'b0;
      if (h == pick(4, c[9], 255)) m_hb = 1'b1;
      else if (h == pick(5, c[9], 255)) m_hb = 1'b0;
      // vertical spans (R6)
      vedge = lf ? (int'(m_live[11]) & 255) : 0;
      if (h == vedge) begin
         if (v == pick(7, c[10], 511)) m_vs = 1'b1;
         else if (v == pick(8, c[10], 511)) m_vs = 1'b0;
      end
      if (h == 0) begin
         if (v == pick(9, c[13], 511)) m_vb = 1'b1;
         else if (v == pick(10, c[13], 511)) m_vb = 1'b0;
      end
      // staging and commit (R3, R4)
      if (el) for (int i = 0; i < 12; i++) m_live[i] = m_staged[i];
      if (we && a < 12) m_staged[a] = d;
      c    = m_live[0];
      e.hs = c[1] ? m_hs : ~m_hs;                                    // R9
      e.vs = c[2] ? m_vs : ~m_vs;
      e.cs = c[3] ? (m_hs ^ m_vs) : ~(m_hs ^ m_vs);                  // R7
      e.bl = c[4] & (m_hb | m_vb);                                   // R8
      exp_q.push_back(e);
   endtask

   task automatic run_line(input int v, input bit lf = 1'b0);
      int ltot;
      ltot = m_live[0][8] ? (int'(m_live[1]) & 255) : 227;
      for (int h = 0; h <= ltot; h++) step(h, v, lf);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // monitor: compares registered outputs one edge after each driven position
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk("R5/R9 hsync", hsync_o, e.hs);
            chk("R6/R9 vsync", vsync_o, e.vs);
            chk("R7 csync", csync_o, e.cs);
            chk("R8 blank", blank_o, e.bl);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; h_cnt = '0; v_cnt = '0; long_field = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      for (int i = 0; i < 12; i++) begin
         m_staged[i] = 16'(dflt(i));
         m_live[i]   = 16'(dflt(i));
      end
      m_hs = 1'b0; m_hb = 1'b0; m_vs = 1'b0; m_vb = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state, active-low syncs idle high, blank low
      chk("R1 hsync reset", hsync_o, 1'b1);
      chk("R1 vsync reset", vsync_o, 1'b1);
      chk("R1 csync reset", csync_o, 1'b1);
      chk("R1 blank reset", blank_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R2/R5/R6: fixed timing, 525-line frame total
      for (int v = 0; v < 6; v++) run_line(v);
      run_line(261);

      // R4/R9: control written mid-line, applies from the next line
      for (int h = 0; h <= 227; h++) step(h, 6, 1'b0, h == 50, 0, 16'h005E);
      run_line(7);
      run_line(30);
      run_line(311);   // R2 625-line total

      // R3/R10: programmable timing, then new control
      for (int h = 0; h <= 227; h++) begin
         if (h >= 1 && h <= 11)
            step(h, 100, 1'b0, 1'b1, h,
                 (h == 1) ? 16'd19 : (h == 2) ? 16'd3 : (h == 3) ? 16'd6 :
                 (h == 4) ? 16'd18 : (h == 5) ? 16'd2 : (h == 6) ? 16'd9 :
                 (h == 7) ? 16'd2 : (h == 8) ? 16'd4 : (h == 9) ? 16'd8 :
                 (h == 10) ? 16'd1 : 16'd10);
         else
            step(h, 100, 1'b0, h == 12, 0, 16'h275E);
      end
      for (int f = 0; f < 2; f++)
         for (int v = 0; v < 10; v++) run_line(v);

      // R6: long field moves vertical sync edges to mid-line position 10
      for (int v = 0; v < 10; v++) run_line(v, 1'b1);

      // R3: writes to unmapped addresses change nothing
      for (int h = 0; h <= 19; h++)
         step(h, 0, 1'b0, h < 4, 12 + h, 16'h0000);
      for (int v = 1; v < 10; v++) run_line(v);
      for (int v = 0; v < 10; v++) run_line(v);

      // R10: clear bit 8, fixed totals return under programmable spans
      for (int h = 0; h <= 19; h++) step(h, 0, 1'b0, h == 3, 0, 16'h265E);
      run_line(1);
      run_line(311);

      repeat (3) @(posedge clk);
      #6;
      summary();
      $finish;
   end
endmodule